// File: doc/BRIEF.md
# Bus Cycle Status Command Decoder

This block sits beside a processor that announces each bus cycle as a 3-bit status code instead of driving separate read and write pins. The code rests at 111 while the bus is idle. The block registers the code on every clock. When it sees the code leave the idle value, it sends out a one-clock address-latch pulse. From the next clock on, it drives one command strobe for the cycle type that was captured, and it holds that strobe until the code goes back to idle.

The cycle type is fixed by the first non-idle code of a cycle. If the code moves between non-idle values before it returns to 111, the strobe does not change. Instruction fetch and data read drive the same memory-read strobe. A halt cycle raises a halt flag instead of a read or write strobe.

Top module: `bus_status_cmd`

## Requirements
- R1: While reset is applied and on the first sample after it is released, all seven outputs are low.
- R2: `addr_latch_o` is high for exactly one clock. That clock comes right after the rising edge that samples the first non-111 status following a sampled 111. The edge that samples 111 just after reset counts as a sampled 111.
- R3: A cycle whose first code is 000 drives `int_ack_o`. The strobe starts on the clock after the address-latch pulse.
- R4: A first code of 001 drives `io_rd_o`, and a first code of 010 drives `io_wr_o`. Each starts on the clock after the address-latch pulse.
- R5: A first code of 100 (fetch) or 101 (data read) drives `mem_rd_o`. The strobe starts on the clock after the address-latch pulse.
- R6: A first code of 110 drives `mem_wr_o`. The strobe starts on the clock after the address-latch pulse.
- R7: A first code of 011 raises `halt_o` and drives no read, write or acknowledge strobe.
- R8: Once a strobe is active, a change of the status to any other non-111 code has no effect. The strobe stays high until the rising edge after the edge that samples 111, and it drops at that edge.
- R9: While the status stays at 111, no output goes high.
- R10: At most one of the six command outputs is high in any cycle, and none of them is high during the address-latch pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_status_i | input | 3 | Encoded bus-cycle status, 111 is idle |
| addr_latch_o | output | 1 | One-clock pulse at the start of a cycle |
| mem_rd_o | output | 1 | Memory read strobe, used for both fetch and data read |
| mem_wr_o | output | 1 | Memory write strobe |
| io_rd_o | output | 1 | I/O read strobe |
| io_wr_o | output | 1 | I/O write strobe |
| int_ack_o | output | 1 | Interrupt acknowledge strobe |
| halt_o | output | 1 | Halt flag |

## Verification
Two events can fall in the same clock: the strobe of one cycle ending and the address-latch pulse of the next cycle starting. This happens when the status shows 111 for a single sample between two active codes. The bench forces this with back-to-back cycles separated by one idle clock, and random stimulus repeats it many times. In that clock the bench expects the old strobe to be gone and the new pulse to be present.

// File: rtl/bus_status_cmd.sv
module bus_status_cmd #(
  parameter int STW = 3,
  parameter logic [STW-1:0] IDLE_CODE = '1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [STW-1:0] bus_status_i,
  output logic           addr_latch_o,
  output logic           mem_rd_o,
  output logic           mem_wr_o,
  output logic           io_rd_o,
  output logic           io_wr_o,
  output logic           int_ack_o,
  output logic           halt_o
);

  localparam int NCMD = 6;

  logic [STW-1:0]  st_q, prev_q;
  logic [NCMD-1:0] cmd_q, cmd_d, dec;
  logic            start, idle_now;

  assign idle_now = (st_q == IDLE_CODE);
  assign start    = (prev_q == IDLE_CODE) && !idle_now;

  // cmd bit order: {int_ack, io_rd, io_wr, halt, mem_rd, mem_wr}
  always_comb begin
    case (st_q)
      3'b000:  dec = 6'b100000;
      3'b001:  dec = 6'b010000;
      3'b010:  dec = 6'b001000;
      3'b011:  dec = 6'b000100;
      3'b100,
      3'b101:  dec = 6'b000010;
      3'b110:  dec = 6'b000001;
      default: dec = 6'b000000;
    endcase
  end

  always_comb begin
    if (start)         cmd_d = dec;
    else if (idle_now) cmd_d = '0;
    else               cmd_d = cmd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= IDLE_CODE;
      prev_q <= IDLE_CODE;
      cmd_q  <= '0;
    end else begin
      st_q   <= bus_status_i;
      prev_q <= st_q;
      cmd_q  <= cmd_d;
    end
  end

  assign addr_latch_o = start;
  assign {int_ack_o, io_rd_o, io_wr_o, halt_o, mem_rd_o, mem_wr_o} = cmd_q;

  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_latch_o |=> !addr_latch_o);                                  // R2
  AST_CMD_FOLLOWS_ALE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_latch_o |=> ($countones(cmd_q) == 1));                       // R3
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({int_ack_o, io_rd_o, io_wr_o, halt_o, mem_rd_o, mem_wr_o})); // R10
  AST_NO_ALE_WITH_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    addr_latch_o |-> (cmd_q == '0));                                  // R10
  AST_HOLD_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_q != '0) && !idle_now) |=> $stable(cmd_q));                 // R8
  AST_DROP_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    idle_now |=> (cmd_q == '0));                                      // R8
  AST_HALT_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> !(mem_rd_o || mem_wr_o || io_rd_o || io_wr_o || int_ack_o)); // R7

endmodule

// File: tb/sim_bus_status_cmd.sv
module sim_bus_status_cmd;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bus_status_i = 3'b111;
  logic ale, mrd, mwr, ird, iwr, iak, hlt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [2:0] m_st = 3'b111, m_prev = 3'b111;
  logic [5:0] m_cmd = '0;

  always #5 clk = ~clk;

  bus_status_cmd u0 (
    .clk(clk), .rst_n(rst_n), .bus_status_i(bus_status_i),
    .addr_latch_o(ale), .mem_rd_o(mrd), .mem_wr_o(mwr),
    .io_rd_o(ird), .io_wr_o(iwr), .int_ack_o(iak), .halt_o(hlt)
  );

  function automatic logic [5:0] type_of(input logic [2:0] c);
    case (c)
      3'b000: return 6'b100000;
      3'b001: return 6'b010000;
      3'b010: return 6'b001000;
      3'b011: return 6'b000100;
      3'b100, 3'b101: return 6'b000010;
      3'b110: return 6'b000001;
      default: return 6'b000000;
    endcase
  endfunction

  function automatic logic exp_ale();
    return (m_prev == 3'b111) && (m_st != 3'b111);
  endfunction

  function automatic string tag_for(input logic [6:0] e);
    if (e[6])    return "R2";
    if (e[5])    return "R3";
    if (e[4] || e[3]) return "R4";
    if (e[2])    return "R7";
    if (e[1])    return "R5";
    if (e[0])    return "R6";
    return "R8/R9";
  endfunction

  task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] c, input string tag);
    logic [6:0] e;
    bus_status_i = c;
    @(posedge clk);
    if (exp_ale()) m_cmd = type_of(m_st);
    else if (m_st == 3'b111) m_cmd = '0;
    m_prev = m_st;
    m_st = c;
    @(negedge clk);
    e = {exp_ale(), m_cmd};
    check((tag == "") ? tag_for(e) : tag, {ale, iak, ird, iwr, hlt, mrd, mwr}, e);
    checks++;
    if (!$onehot0({iak, ird, iwr, hlt, mrd, mwr}) || (ale && |{iak, ird, iwr, hlt, mrd, mwr})) begin
      errors++;
      $display("FAIL R10 actual=%b expected=onehot0", {ale, iak, ird, iwr, hlt, mrd, mwr});
    end
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] r;
    int unsigned s;
    s = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    check("R1", {ale, iak, ird, iwr, hlt, mrd, mwr}, 7'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {ale, iak, ird, iwr, hlt, mrd, mwr}, 7'b0);

    // R9: idle stays quiet
    repeat (4) step(3'b111, "R9");
    // R3..R7 each type, plus fetch for R5
    for (int k = 0; k < 7; k++) begin
      step(3'(k), "");
      step(3'(k), "");
      step(3'(k), "");
      step(3'b111, "R8");
      step(3'b111, "R8");
    end
    // R8: code moves among non-idle values, type must hold
    step(3'b001, "R2");
    step(3'b110, "R4");
    step(3'b000, "R8");
    step(3'b011, "R8");
    step(3'b111, "R8");
    step(3'b111, "R8");
    // back-to-back cycles with one idle sample between (R10 coincidence)
    step(3'b101, "R2");
    step(3'b101, "R5");
    step(3'b111, "R5");
    step(3'b110, "R10");
    step(3'b110, "R6");
    step(3'b111, "R6");
    step(3'b000, "R10");
    step(3'b111, "R2");
    step(3'b111, "R3");
    // random: half idle, half any code
    for (int i = 0; i < 600; i++) begin
      r = ($urandom() % 2) ? 3'b111 : 3'($urandom() % 8);
      step(r, "");
    end
    repeat (3) step(3'b111, "R9");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule